// File: doc/BRIEF.md
# TDM Backplane Clock and Frame Strobe Generator

This block sits behind the digitally controlled oscillator of a timing loop. It turns the oscillator's timing ticks into a set of backplane clocks and three 8 kHz frame strobes. The block and the oscillator run on the same master clock. Two tick inputs are used. The E1 tick fires once per half period of the 16.384 MHz clock, which gives 4096 ticks per 125 µs frame. The T1 tick fires once per half period of the 3.088 MHz clock, which gives 772 ticks per frame. A third input, the frame tick, marks the 125 µs boundary. On every frame tick both position counters return to zero, so the two clock families and the strobes stay phase-aligned.

The E1 family (16.384, 8.192, 4.096 and 2.048 MHz) is taken from a binary counter. The T1 family (3.088 and 1.544 MHz) is taken from a modulo-772 counter. Three strobes are decoded from the E1 position:
- An active-low strobe one 4.096 MHz period wide, centred on the boundary.
- An active-high strobe one 8.192 MHz period wide, also centred on the boundary.
- An active-high strobe of the same width that starts at the boundary.

One position unit is one E1 tick. Every output is registered.

Top module: `tdm_clock_framer`

## Requirements
- R1: After reset (synchronous, active high), and until the first frame tick, every clock output is 0, `f0_n` is 1 and `fp_stb` and `fp_gci` are 0. E1 and T1 ticks in that interval have no effect.
- R2: A frame tick sets the E1 position to 0. After that, each E1 tick advances the position by one, and the position wraps from 4095 to 0 without a frame tick.
- R3: The E1 clocks show bits of the E1 position: `c16` is bit 0, `c8` is bit 1, `c4` is bit 2 and `c2` is bit 3.
- R4: A frame tick sets the T1 position to 0. Each T1 tick advances it by one, with a wrap from 771 to 0. `c3` is bit 0 of the T1 position and `c1p5` is bit 1.
- R5: `f0_n` is 0 while the E1 position is 4092 to 4095 or 0 to 3, and 1 otherwise. This is eight units, centred on the boundary.
- R6: `fp_stb` is 1 while the E1 position is 4094, 4095, 0 or 1, and 0 otherwise.
- R7: `fp_gci` is 1 while the E1 position is 0 to 3, and 0 otherwise.
- R8: A frame tick takes priority over an E1 or T1 tick in the same cycle. Both families realign in the same cycle, so `c2` and `c1p5` come out of one register stage together.
- R9: A position changes at the clock edge that samples its tick. The outputs reflect that position at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_tick | input | 1 | 8 kHz frame boundary tick from the oscillator |
| e1_tick | input | 1 | Half-period tick of the 16.384 MHz clock |
| t1_tick | input | 1 | Half-period tick of the 3.088 MHz clock |
| c16 | output | 1 | 16.384 MHz clock |
| c8 | output | 1 | 8.192 MHz clock |
| c4 | output | 1 | 4.096 MHz clock |
| c2 | output | 1 | 2.048 MHz clock |
| c3 | output | 1 | 3.088 MHz clock |
| c1p5 | output | 1 | 1.544 MHz clock |
| f0_n | output | 1 | Active-low frame strobe, one 4.096 MHz period wide |
| fp_stb | output | 1 | Active-high frame strobe, one 8.192 MHz period wide, centred |
| fp_gci | output | 1 | Active-high frame strobe, one 8.192 MHz period wide, starting at the boundary |

## Verification
A tick or frame tick sampled at edge k moves the position at edge k, and the outputs show the result at edge k+1. The first falling edge at which the effect can be seen is therefore the one after edge k+1. The bench keeps reference positions that it updates at each rising edge, and holds a one-edge-old copy of them. At every falling edge it compares all nine outputs with values decoded from that copy. The directed checks for arming, wrap and realignment are placed at the second falling edge after the stimulus, which is where R9 puts the result.

// File: rtl/tdmfp_pkg.sv
package tdmfp_pkg;

  // Active-high view of the three frame strobes, before output polarity.
  typedef struct packed {
    logic f0;
    logic stb;
    logic gci;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{f0: 1'b0, stb: 1'b0, gci: 1'b0};

endpackage

// File: rtl/phase_wheel.sv
// Modulo-MOD position counter. It is cleared by align, advanced by step
// only while run is set, and shows its low NTAP bits.
module phase_wheel #(
  parameter int MOD  = 4096,
  parameter int NTAP = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            align,
  input  logic            run,
  input  logic            step,
  output logic [NTAP-1:0] tap
);
  localparam int PW = (MOD > 1) ? $clog2(MOD) : 1;
  localparam logic [PW-1:0] LAST = PW'(MOD - 1);

  logic [PW-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst || align) begin
      pos <= '0;
    end else if (run && step) begin
      pos <= (pos == LAST) ? '0 : pos + 1'b1;
    end
  end

  assign tap = pos[NTAP-1:0];
endmodule

// File: rtl/frame_strobe_decode.sv
// Decodes the three frame strobe windows from the E1 position.
module frame_strobe_decode
  import tdmfp_pkg::*;
#(
  parameter int CELLS    = 4096,
  parameter int F0_HALF  = 4,
  parameter int STB_HALF = 2,
  parameter int GCI_LEN  = 4
) (
  input  logic [$clog2(CELLS)-1:0] pos,
  output strobe_t                  win
);
  localparam int PW = $clog2(CELLS);
  localparam logic [PW-1:0] F0_LO  = PW'(F0_HALF);
  localparam logic [PW-1:0] F0_HI  = PW'(CELLS - F0_HALF);
  localparam logic [PW-1:0] STB_LO = PW'(STB_HALF);
  localparam logic [PW-1:0] STB_HI = PW'(CELLS - STB_HALF);
  localparam logic [PW-1:0] GCI_HI = PW'(GCI_LEN);

  always_comb begin
    win.f0  = (pos < F0_LO) || (pos >= F0_HI);
    win.stb = (pos < STB_LO) || (pos >= STB_HI);
    win.gci = (pos < GCI_HI);
  end
endmodule

// File: rtl/tdm_clock_framer.sv
module tdm_clock_framer
  import tdmfp_pkg::*;
#(
  parameter int E1_CELLS = 4096,
  parameter int T1_CELLS = 772,
  parameter int F0_HALF  = 4,
  parameter int STB_HALF = 2,
  parameter int GCI_LEN  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_tick,
  input  logic e1_tick,
  input  logic t1_tick,
  output logic c16,
  output logic c8,
  output logic c4,
  output logic c2,
  output logic c3,
  output logic c1p5,
  output logic f0_n,
  output logic fp_stb,
  output logic fp_gci
);
  localparam int EW      = $clog2(E1_CELLS);
  localparam int E1_TAPS = 4;
  localparam int T1_TAPS = 2;

  logic               armed;
  logic [EW-1:0]      e1_pos;
  logic [T1_TAPS-1:0] t1_tap;
  strobe_t            win;
  logic [E1_TAPS-1:0] e1_clk_q;
  logic [T1_TAPS-1:0] t1_clk_q;
  strobe_t            win_q;

  // The block is armed by the first frame tick after reset.
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else if (frame_tick) armed <= 1'b1;
  end

  phase_wheel #(.MOD(E1_CELLS), .NTAP(EW)) u_e1_wheel (
    .clk(clk), .rst(rst), .align(frame_tick), .run(armed),
    .step(e1_tick), .tap(e1_pos)
  );

  phase_wheel #(.MOD(T1_CELLS), .NTAP(T1_TAPS)) u_t1_wheel (
    .clk(clk), .rst(rst), .align(frame_tick), .run(armed),
    .step(t1_tick), .tap(t1_tap)
  );

  frame_strobe_decode #(
    .CELLS(E1_CELLS), .F0_HALF(F0_HALF), .STB_HALF(STB_HALF), .GCI_LEN(GCI_LEN)
  ) u_decode (
    .pos(e1_pos), .win(win)
  );

  // Output register stage. Every output is held idle until armed.
  genvar gi;
  generate
    for (gi = 0; gi < E1_TAPS; gi++) begin : g_e1_out
      always_ff @(posedge clk) begin
        if (rst || !armed) e1_clk_q[gi] <= 1'b0;
        else               e1_clk_q[gi] <= e1_pos[gi];
      end
    end
    for (gi = 0; gi < T1_TAPS; gi++) begin : g_t1_out
      always_ff @(posedge clk) begin
        if (rst || !armed) t1_clk_q[gi] <= 1'b0;
        else               t1_clk_q[gi] <= t1_tap[gi];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !armed) win_q <= STROBE_IDLE;
    else               win_q <= win;
  end

  assign c16    = e1_clk_q[0];
  assign c8     = e1_clk_q[1];
  assign c4     = e1_clk_q[2];
  assign c2     = e1_clk_q[3];
  assign c3     = t1_clk_q[0];
  assign c1p5   = t1_clk_q[1];
  assign f0_n   = ~win_q.f0;
  assign fp_stb = win_q.stb;
  assign fp_gci = win_q.gci;
endmodule

// File: rtl/tdm_clock_framer_chk.sv
module tdm_clock_framer_chk (
  input logic clk,
  input logic rst,
  input logic frame_tick,
  input logic e1_tick,
  input logic t1_tick,
  input logic c16,
  input logic c8,
  input logic c4,
  input logic c2,
  input logic c3,
  input logic c1p5,
  input logic f0_n,
  input logic fp_stb,
  input logic fp_gci
);
  logic unused_in;
  assign unused_in = e1_tick ^ t1_tick;

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    rst |=> (!c16 && !c8 && !c4 && !c2 && !c3 && !c1p5 && f0_n && !fp_stb && !fp_gci));

  assert_c8_rises_on_c16_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(c8) |-> $fell(c16));

  assert_c1p5_rises_on_c3_fall_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(c1p5) |-> $fell(c3));

  assert_stb_inside_f0_R5: assert property (@(posedge clk) disable iff (rst)
    fp_stb |-> !f0_n);

  assert_gci_start_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(fp_gci) |-> (!f0_n && fp_stb));

  assert_frame_realign_R8: assert property (@(posedge clk) disable iff (rst)
    frame_tick |-> ##2 (fp_gci && !f0_n && !c16 && !c8 && !c4 && !c2 && !c3 && !c1p5));
endmodule

bind tdm_clock_framer tdm_clock_framer_chk u_chk (.*);

// File: tb/tdm_clock_framer_bench.sv
`timescale 1ns/1ps
module tdm_clock_framer_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_tick = 1'b0, e1_tick = 1'b0, t1_tick = 1'b0;
  logic c16, c8, c4, c2, c3, c1p5, f0_n, fp_stb, fp_gci;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  tdm_clock_framer u_tdm_clock_framer (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .e1_tick(e1_tick),
    .t1_tick(t1_tick), .c16(c16), .c8(c8), .c4(c4), .c2(c2), .c3(c3),
    .c1p5(c1p5), .f0_n(f0_n), .fp_stb(fp_stb), .fp_gci(fp_gci)
  );

  // Reference positions, taken from the requirements (R2, R4, R8).
  int epos = 0, tpos = 0, epos_d = 0, tpos_d = 0;
  bit run = 0, run_d = 0;

  always @(posedge clk) begin
    epos_d <= epos; tpos_d <= tpos; run_d <= run;
    if (rst) begin
      epos <= 0; tpos <= 0; run <= 0; run_d <= 0;
    end else if (frame_tick) begin
      epos <= 0; tpos <= 0; run <= 1;
    end else begin
      if (run && e1_tick) epos <= (epos == 4095) ? 0 : epos + 1;
      if (run && t1_tick) tpos <= (tpos == 771) ? 0 : tpos + 1;
    end
  end

  function automatic bit exp_f0(int p);  return !((p <= 3) || (p >= 4092)); endfunction
  function automatic bit exp_stb(int p); return (p <= 1) || (p >= 4094);    endfunction
  function automatic bit exp_gci(int p); return p <= 3;                     endfunction

  task automatic check(string req, string sig, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", req, sig, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison against the one-edge-old reference (R9).
  always @(negedge clk) begin
    cyc++;
    check("R3", "c16",  c16,  run_d ? 1'(epos_d & 1)        : 1'b0);
    check("R3", "c8",   c8,   run_d ? 1'((epos_d >> 1) & 1) : 1'b0);
    check("R3", "c4",   c4,   run_d ? 1'((epos_d >> 2) & 1) : 1'b0);
    check("R3", "c2",   c2,   run_d ? 1'((epos_d >> 3) & 1) : 1'b0);
    check("R4", "c3",   c3,   run_d ? 1'(tpos_d & 1)        : 1'b0);
    check("R4", "c1p5", c1p5, run_d ? 1'((tpos_d >> 1) & 1) : 1'b0);
    check("R5", "f0_n", f0_n, run_d ? exp_f0(epos_d)  : 1'b1);
    check("R6", "fp_stb", fp_stb, run_d ? exp_stb(epos_d) : 1'b0);
    check("R7", "fp_gci", fp_gci, run_d ? exp_gci(epos_d) : 1'b0);
    if (cyc > 190000) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic step(bit f, bit e, bit t);
    @(negedge clk);
    frame_tick = f; e1_tick = e; t1_tick = t;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    check("R1", "f0_n in reset", f0_n, 1'b1);
    rst = 0;
    // R1: ticks before the first frame tick are ignored.
    for (int i = 0; i < 40; i++) step(0, 1, 1);
    step(0, 0, 0);
    check("R1", "c16 before arm", c16, 1'b0);
    check("R1", "c3 before arm",  c3,  1'b0);
    // R9: arming becomes visible at the second falling edge.
    step(1, 0, 0);
    step(0, 0, 0);
    check("R9", "f0_n one edge after tick", f0_n, 1'b1);
    @(negedge clk);
    check("R9", "f0_n two edges after tick", f0_n, 1'b0);
    // R2: full frame of E1 ticks without a frame tick wraps to 0.
    step(1, 0, 0);
    for (int i = 0; i < 4096; i++) step(0, 1, 1);
    step(0, 0, 0);
    check("R2", "fp_stb at 4095", fp_stb, 1'b1);
    check("R2", "fp_gci at 4095", fp_gci, 1'b0);
    @(negedge clk);
    check("R2", "fp_gci after wrap", fp_gci, 1'b1);
    // R8: frame tick mid-frame together with both ticks.
    for (int i = 0; i < 1234; i++) step(0, 1, 1);
    step(1, 1, 1);
    step(0, 0, 0);
    @(negedge clk);
    check("R8", "fp_gci realign", fp_gci, 1'b1);
    check("R8", "c2 realign",     c2,     1'b0);
    check("R8", "c1p5 realign",   c1p5,   1'b0);
    // Random ticks with occasional frame ticks at arbitrary positions.
    for (int i = 0; i < 40000; i++)
      step(($urandom % 2500) == 0, ($urandom % 8) != 0, ($urandom % 4) == 0);
    // R1: reset mid-run returns every output to idle.
    @(negedge clk); rst = 1;
    step(0, 1, 1);
    step(0, 1, 1);
    check("R1", "f0_n after reset", f0_n, 1'b1);
    check("R1", "c16 after reset",  c16,  1'b0);
    rst = 0;
    for (int i = 0; i < 20; i++) step(0, 1, 1);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule